// File: doc/BRIEF.md
# Converter Bus Interface Controller

This block is the digital side of an 8-bit successive-approximation converter that sits on a processor bus. The processor talks to it through three active-low strobes: chip select, write and read. It also uses the shared data lines. During a write, the low data lines carry a five-bit input configuration, which the block latches and presents to the analog multiplexer. The block then runs a conversion. It has a sampling phase first, and after that it resolves one result bit per clock, starting with the most significant bit. On each bit it drives a trial code to the ladder and reads back a single comparator bit. When the conversion ends, the result moves into an output latch and the active-low interrupt flag goes low.

A read drives the latched result onto the bus and clears the interrupt. When the read ends, it also starts a new conversion on the configuration already held. There are two ways to start a conversion without changing the configuration:
- a plain read;
- a write pulse issued while the read strobe is held low for the whole write.

All strobes and the configuration lines are synchronised to the block clock before the edges are detected. A conversion started while another is still running abandons the older one.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `mux_cfg` is 5'b01000 (mode field bits 4:3 = 01, channel field bits 2:0 = 0), `db_oe` is 0 and `db_out` is 0.
- R2: When the write strobe ends (`wr_n` rises with `cs_n` low) and `rd_n` was high at some point during the write, `mux_cfg` takes the value that `db_in` held when the rising `wr_n` was first sampled.
- R3: If `rd_n` stays low for the whole time `wr_n` is low, `mux_cfg` keeps its old value. The bus meanwhile shows the previous result, and the end of the write still starts a conversion.
- R4: A falling write strobe with `cs_n` low returns `intr_n` to 1 within SYNC_STAGES+1 clock edges.
- R5: A conversion lasts a fixed time. When `wr_n` rises at clock edge E0, the output latch is loaded and `intr_n` goes low at edge E0+SYNC_STAGES+SETTLE_CYC+WIDTH+1. That is edge E0+12 with the default parameters.
- R6: Each conversion starts with SETTLE_CYC cycles in which `sample_en` is 1 and `trial_code` is 0. Next come WIDTH bit cycles, MSB first. The first trial code is 8'h80. With the comparator reporting (plus − minus) ≥ trial, the result is the difference, clamped to 255.
- R7: When the "+" input is below the "−" input, the result is 8'h00.
- R8: `db_oe` is 1 exactly while `cs_n` and `rd_n` are both low, and `db_out` then carries the output latch. Otherwise `db_out` is 0.
- R9: A read clears `intr_n` to 1. The end of a read that had no write inside it starts a new conversion with `mux_cfg` unchanged.
- R10: A conversion started while another is running abandons the older one. Only one completion follows, and its timing and result belong to the newer start.
- R11: Strobes given while `cs_n` is high have no effect. `mux_cfg`, `intr_n`, the output latch and `db_oe` all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which also paces the conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| db_in | input | 5 | Low data lines, sampled as the input configuration |
| db_out | output | 8 | Data lines driven toward the bus |
| db_oe | output | 1 | Output enable for the data lines |
| intr_n | output | 1 | Conversion-complete flag, active low |
| mux_cfg | output | 5 | Latched multiplexer configuration (mode in bits 4:3, channel in 2:0) |
| sample_en | output | 1 | High during the sampling cycles of a conversion |
| trial_code | output | 8 | Code driven to the ladder for the current comparison |
| cmp_in | input | 1 | Comparator result: 1 when the input difference is at least `trial_code` |

## Verification
The assertions check several rules on every clock cycle:
- a finished conversion pulls the interrupt low on the next edge;
- a clear with no completion in the same cycle raises it;
- the configuration moves only on a load event;
- the trial code is zero while sampling and equals the MSB weight on the first bit cycle;
- every completion comes exactly SETTLE_CYC+WIDTH cycles after the latest start.

The bench scenarios cover what a property over internal events cannot show. They measure the end-to-end latency from the strobe pins and check the arithmetic result of each input configuration, including clamping and negative differences. They also check how the keep-configuration write and the read-started conversion behave, and that strobes are ignored while the chip is not selected.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  // Phases of one conversion.
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_BITS   = 2'd2
  } seq_state_e;

  // Mode field value for a ground-referenced single input.
  localparam logic [1:0] MODE_SINGLE = 2'b01;

  // One-cycle events decoded from the synchronised strobes.
  typedef struct packed {
    logic cfg_load;    // latch a new configuration
    logic conv_start;  // begin (or restart) a conversion
    logic intr_clear;  // return the interrupt flag high
  } strobe_evt_t;

endpackage

// File: rtl/cvt_strobe_sync.sv
module cvt_strobe_sync
  import cvt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_sync,
  output strobe_evt_t       evt
);

  localparam int VEC_W = DATA_W + 3;
  localparam logic [VEC_W-1:0] VEC_IDLE = {3'b111, {DATA_W{1'b0}}};

  // Strobes and configuration lines travel through the same chain, so the
  // sampled data stays aligned with the strobe edge that uses it.
  logic [VEC_W-1:0] chain [SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= VEC_IDLE;
          else        chain[g] <= {cs_n, wr_n, rd_n, db_in};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= VEC_IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  logic [VEC_W-1:0] last;
  logic s_cs, s_wr, s_rd;
  assign last    = chain[SYNC_STAGES-1];
  assign s_cs    = last[VEC_W-1];
  assign s_wr    = last[VEC_W-2];
  assign s_rd    = last[VEC_W-3];
  assign db_sync = last[DATA_W-1:0];

  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q;
  logic rd_hi_q;     // read strobe seen high during the current write
  logic wr_in_rd_q;  // a write occurred during the current read

  assign wr_act = ~s_cs & ~s_wr;
  assign rd_act = ~s_cs & ~s_rd;

  logic wr_start, wr_end, rd_start, rd_end;
  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = ~wr_act & wr_act_q;
  assign rd_start = rd_act & ~rd_act_q;
  assign rd_end   = ~rd_act & rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q   <= 1'b0;
      rd_act_q   <= 1'b0;
      rd_hi_q    <= 1'b0;
      wr_in_rd_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_start)               rd_hi_q <= ~rd_act;
      else if (wr_act && !rd_act) rd_hi_q <= 1'b1;
      if (rd_start)               wr_in_rd_q <= wr_act;
      else if (rd_act && wr_act)  wr_in_rd_q <= 1'b1;
    end
  end

  logic read_start;
  assign read_start = rd_end & ~wr_in_rd_q & ~wr_act;

  always_comb begin
    evt.cfg_load   = wr_end & rd_hi_q;
    evt.conv_start = wr_end | read_start;
    evt.intr_clear = wr_start | rd_start;
  end

endmodule

// File: rtl/cvt_sar_seq.sv
module cvt_sar_seq
  import cvt_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SETTLE_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] trial_code,
  output logic             sample_en,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_e       state_q;
  logic [WIDTH-1:0] sar_q, sar_nxt, bit_mask;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [WIDTH-1:0] result_q;

  always_comb begin
    bit_mask = '0;
    if (state_q == SQ_BITS) bit_mask[idx_q] = 1'b1;
    trial_code     = sar_q | bit_mask;
    sar_nxt        = sar_q;
    sar_nxt[idx_q] = cmp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      sar_q    <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q <= SQ_SETTLE;
        sar_q   <= '0;
        cnt_q   <= '0;
        idx_q   <= MSB_IDX;
      end else begin
        case (state_q)
          SQ_SETTLE: begin
            if (cnt_q == CNT_LAST) state_q <= SQ_BITS;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
          SQ_BITS: begin
            sar_q <= sar_nxt;
            if (idx_q == '0) begin
              state_q  <= SQ_IDLE;
              result_q <= sar_nxt;
              done_q   <= 1'b1;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sample_en = (state_q == SQ_SETTLE);
  assign done      = done_q;
  assign result    = result_q;

endmodule

// File: rtl/cvt_out_latch.sv
module cvt_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [WIDTH-1:0] result,
  input  logic             intr_clear,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] db_out,
  output logic             db_oe,
  output logic             intr_n
);

  logic [WIDTH-1:0] data_q;
  logic             intr_q;

  // A completing conversion wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      intr_q <= 1'b1;
    end else if (done) begin
      data_q <= result;
      intr_q <= 1'b0;
    end else if (intr_clear) begin
      intr_q <= 1'b1;
    end
  end

  assign db_oe  = ~cs_n & ~rd_n;
  assign db_out = db_oe ? data_q : '0;
  assign intr_n = intr_q;

endmodule

// File: rtl/cvt_bus_ctrl.sv
module cvt_bus_ctrl
  import cvt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 1,
  parameter logic [ADDR_W-1:0] CFG_RESET = ADDR_W'({MODE_SINGLE, 3'b000})
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] db_in,
  output logic [WIDTH-1:0]  db_out,
  output logic              db_oe,
  output logic              intr_n,
  output logic [ADDR_W-1:0] mux_cfg,
  output logic              sample_en,
  output logic [WIDTH-1:0]  trial_code,
  input  logic              cmp_in
);

  strobe_evt_t       evt;
  logic [ADDR_W-1:0] db_sync;
  logic              cfg_load, conv_start, intr_clear;
  logic              conv_done;
  logic [WIDTH-1:0]  conv_result;
  logic [ADDR_W-1:0] cfg_q;

  cvt_strobe_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (ADDR_W)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .db_in   (db_in),
    .db_sync (db_sync),
    .evt     (evt)
  );

  assign cfg_load   = evt.cfg_load;
  assign conv_start = evt.conv_start;
  assign intr_clear = evt.intr_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_load) cfg_q <= db_sync;
  end
  assign mux_cfg = cfg_q;

  cvt_sar_seq #(
    .WIDTH      (WIDTH),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (conv_start),
    .cmp_in     (cmp_in),
    .trial_code (trial_code),
    .sample_en  (sample_en),
    .done       (conv_done),
    .result     (conv_result)
  );

  cvt_out_latch #(
    .WIDTH (WIDTH)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (conv_done),
    .result     (conv_result),
    .intr_clear (intr_clear),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .db_out     (db_out),
    .db_oe      (db_oe),
    .intr_n     (intr_n)
  );

endmodule

// File: rtl/cvt_bus_ctrl_chk.sv
module cvt_bus_ctrl_chk #(
  parameter int WIDTH      = 8,
  parameter int ADDR_W     = 5,
  parameter int SETTLE_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              conv_start,
  input logic              intr_clear,
  input logic              conv_done,
  input logic              intr_n,
  input logic [ADDR_W-1:0] mux_cfg,
  input logic              sample_en,
  input logic [WIDTH-1:0]  trial_code
);

  localparam int CONV_LEN = SETTLE_CYC + WIDTH;
  localparam int CW       = $clog2(CONV_LEN + 2);

  logic [CW-1:0] run_cnt;
  logic          running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      running <= 1'b0;
    end else if (conv_start) begin
      run_cnt <= '0;
      running <= 1'b1;
    end else if (conv_done) begin
      running <= 1'b0;
    end else if (running && run_cnt != CW'(CONV_LEN + 1)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  p_intr_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !intr_n);

  p_clear_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_clear && !conv_done) |=> intr_n);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(mux_cfg));

  p_settle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (trial_code == '0));

  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> (trial_code == {1'b1, {(WIDTH-1){1'b0}}}));

  p_conv_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (running && run_cnt == CW'(CONV_LEN)));

endmodule

bind cvt_bus_ctrl cvt_bus_ctrl_chk #(
  .WIDTH      (WIDTH),
  .ADDR_W     (ADDR_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .conv_start (conv_start),
  .intr_clear (intr_clear),
  .conv_done  (conv_done),
  .intr_n     (intr_n),
  .mux_cfg    (mux_cfg),
  .sample_en  (sample_en),
  .trial_code (trial_code)
);

// File: tb/cvt_bus_ctrl_test.sv
module cvt_bus_ctrl_test;

  localparam int CLK_PERIOD  = 10;
  localparam int WIDTH       = 8;
  localparam int ADDR_W      = 5;
  localparam int SYNC_STAGES = 2;
  localparam int SETTLE_CYC  = 1;
  localparam int LAT         = SYNC_STAGES + SETTLE_CYC + WIDTH + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [ADDR_W-1:0] db_in = '0;
  logic [WIDTH-1:0]  db_out, trial_code;
  logic              db_oe, intr_n, sample_en;
  logic [ADDR_W-1:0] mux_cfg;
  logic              cmp_in = 1'b0;

  int chv [8];
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  cvt_bus_ctrl #(
    .WIDTH (WIDTH), .ADDR_W (ADDR_W), .SYNC_STAGES (SYNC_STAGES), .SETTLE_CYC (SETTLE_CYC)
  ) uut (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .wr_n (wr_n), .rd_n (rd_n),
    .db_in (db_in), .db_out (db_out), .db_oe (db_oe), .intr_n (intr_n),
    .mux_cfg (mux_cfg), .sample_en (sample_en), .trial_code (trial_code), .cmp_in (cmp_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Analog model: mode 00 differential pair, 10 against channel 7, else single.
  function automatic int diff_of(logic [4:0] cfg);
    int s, e, p, m;
    s = int'(cfg[2:0]);
    e = s & 6;
    case (cfg[4:3])
      2'b00: begin
        if (cfg[0]) begin p = chv[e+1]; m = chv[e]; end
        else        begin p = chv[e];   m = chv[e+1]; end
      end
      2'b10:   begin p = chv[s]; m = chv[7]; end
      default: begin p = chv[s]; m = 0; end
    endcase
    return p - m;
  endfunction

  function automatic logic [7:0] code_of(logic [4:0] cfg);
    int d;
    d = diff_of(cfg);
    if (d < 0)   return 8'h00;
    if (d > 255) return 8'hFF;
    return d[7:0];
  endfunction

  always @(negedge clk) cmp_in <= (diff_of(mux_cfg) >= int'(trial_code));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [4:0] cfg, output int lat, output int samp,
                        output logic [7:0] first_trial);
    logic prev_s;
    cs_n = 1'b0; db_in = cfg; cyc(1);
    wr_n = 1'b0; cyc(4);
    check("R4", intr_n, 1, "intr_n after write strobe falls");
    wr_n = 1'b1;
    lat = 0; samp = 0; first_trial = 8'h00; prev_s = 1'b0;
    for (int i = 1; i <= LAT + 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 3) begin cs_n = 1'b1; db_in = ~cfg; end
      if (sample_en) samp++;
      if (prev_s && !sample_en) first_trial = trial_code;
      prev_s = sample_en;
      if (!intr_n) begin lat = i; break; end
    end
    cs_n = 1'b1;
  endtask

  task automatic rd_data(output logic [7:0] d);
    cs_n = 1'b0; rd_n = 1'b0; cyc(4);
    d = db_out;
    check("R8", db_oe, 1, "db_oe during read");
    check("R9", intr_n, 1, "intr_n cleared by read");
    rd_n = 1'b1; cs_n = 1'b1; cyc(1);
  endtask

  task automatic full_conv(logic [4:0] cfg, string tag);
    int lat, samp;
    logic [7:0] ft, d, exp;
    exp = code_of(cfg);
    wr_cfg(cfg, lat, samp, ft);
    check("R5", lat, LAT, "latency from write end to intr_n low");
    check("R6", samp, SETTLE_CYC, "sampling cycles");
    check("R6", ft, 8'h80, "first trial code");
    check("R2", mux_cfg, cfg, "latched configuration");
    rd_data(d);
    check(tag, d, exp, "conversion result");
    cyc(LAT + 5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev_res;
    int lat, samp;
    logic [7:0] ft;
    chv = '{37, 200, 90, 15, 255, 128, 60, 10};
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state, R8 idle bus
    check("R1", intr_n, 1, "intr_n after reset");
    check("R1", mux_cfg, 5'b01000, "mux_cfg after reset");
    check("R1", db_oe, 0, "db_oe after reset");
    check("R8", db_out, 0, "db_out idle");

    // Sweep of every mode and channel
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 8; s++) begin
        logic [4:0] cfg;
        cfg = {m[1:0] == 2'd0 ? 2'b00 : (m[1:0] == 2'd1 ? 2'b01 : 2'b10), s[2:0]};
        full_conv(cfg, (diff_of(cfg) < 0) ? "R7" : "R6");
      end
    end

    // Exhaustive single-ended values including clamping
    for (int v = 0; v <= 300; v++) begin
      chv[0] = v;
      full_conv(5'b01000, "R6");
    end

    // Explicit negative difference, R7, and its swapped pair, R6
    chv[0] = 20; chv[1] = 100;
    full_conv(5'b00000, "R7");
    full_conv(5'b00001, "R6");

    // R9: read-started conversion uses the unchanged configuration
    chv[3] = 77;
    full_conv(5'b01011, "R6");
    chv[3] = 140;
    rd_data(d);
    check("R9", d, 8'd77, "read returns previous result");
    for (int i = 0; i < LAT + 10 && intr_n; i++) cyc(1);
    check("R9", intr_n, 0, "read-started conversion completes");
    check("R9", mux_cfg, 5'b01011, "configuration kept after read");
    rd_data(d);
    check("R9", d, 8'd140, "read-started conversion result");
    cyc(LAT + 5);

    // R3: read held low across a write keeps configuration
    prev_res = 8'd140;
    chv[3] = 33;
    cs_n = 1'b0; rd_n = 1'b0; db_in = 5'b10010; cyc(2);
    check("R3", db_out, prev_res, "previous result on bus");
    wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(4);
    rd_n = 1'b1; cs_n = 1'b1;
    check("R3", mux_cfg, 5'b01011, "configuration kept");
    for (int i = 0; i < LAT + 10 && intr_n; i++) cyc(1);
    check("R3", intr_n, 0, "conversion started by kept-config write");
    rd_data(d);
    check("R3", d, 8'd33, "result with kept configuration");
    cyc(LAT + 5);

    // R10: second write aborts a running conversion
    chv[4] = 201; chv[5] = 66;
    cs_n = 1'b0; db_in = 5'b01100; cyc(1);
    wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(2);
    wr_cfg(5'b01101, lat, samp, ft);
    check("R10", lat, LAT, "latency measured from restarting write");
    rd_data(d);
    check("R10", d, 8'd66, "result of restarting conversion");
    cyc(LAT + 5);

    // R11: strobes without chip select are ignored
    full_conv(5'b01100, "R6");
    check("R11", intr_n, 0, "intr_n low before deselected strobes");
    cs_n = 1'b1; db_in = 5'b10111;
    wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(2);
    rd_n = 1'b0; cyc(2);
    check("R11", db_oe, 0, "db_oe with chip deselected");
    check("R8", db_out, 0, "db_out with chip deselected");
    rd_n = 1'b1; cyc(LAT + 5);
    check("R11", mux_cfg, 5'b01100, "configuration unchanged");
    check("R11", intr_n, 0, "intr_n unchanged");
    rd_data(d);
    check("R11", d, 8'd201, "output latch unchanged");
    cyc(LAT + 5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule